// File: doc/BRIEF.md
# Debug Serial Link Timeout Controller

This block watches a single-wire debug link whose traffic is marked by falling edges on the wire. It measures the gap, in clock cycles, since the last significant event. It tracks whether the link is idle, partway through an incoming command, holding a completed read until the host collects it, or partway through returning data. When a gap exceeds the limit in a phase that is timed, it emits a one-cycle soft reset. That reset discards the pending work and returns the link to idle, so the next falling edge starts a fresh command or a sync request.

Neighbouring logic does the bit decoding and reports three events: a command has been fully received (and whether it was a read), and the returned data is complete. It also reports when an acknowledge pulse has gone out on the wire. Software controls the handshake mode through a single register bit. While handshaking is on, a completed read may wait without any time limit until the acknowledge pulse re-arms the timer. A strobe marking the restart of clocks after a low-power exit forces a soft reset and turns handshaking off.

Top module: `dbg_link_watchdog`

## Requirements
- R1: After reset, `link_state` is 0 (idle), `soft_rst` is 0 and `hs_en` is 0.
- R2: `link_pin` passes through a two-flop synchronizer before falling-edge detection. A falling edge seen in idle moves `link_state` to 1 (command) on the third rising clock edge after the pin goes low. The state codes are 0 idle, 1 command, 2 read pending, 3 data return.
- R3: In state 1 or 3, if TIMEOUT_CYC cycles pass with no falling edge, `soft_rst` pulses and the state returns to 0. Edges spaced closer than that keep the transfer alive.
- R4: With `hs_en` at 0, a read left uncollected for TIMEOUT_CYC cycles after `cmd_done` with `cmd_read` high causes a soft reset and a return to idle.
- R5: With `hs_en` at 1, state 2 is never timed out before an acknowledge, however long the host waits.
- R6: An `ack_sent` strobe in state 2 while `hs_en` is 1 restarts the gap count and re-arms the limit. Without a falling edge within TIMEOUT_CYC cycles after it, the read is discarded with a soft reset.
- R7: In idle no soft reset is ever produced, and the gap count saturates rather than wrapping.
- R8: A timeout soft reset is high for exactly one cycle, and `link_state` reads 0 in that same cycle.
- R9: After a timeout, the next falling edge starts a new command (state 1).
- R10: A `wake` strobe produces a soft reset in the next cycle, forces state 0 and clears `hs_en`.
- R11: `hs_wr` loads `hs_wdata` into `hs_en`. A wake in the same cycle wins and clears it.
- R12: In state 1, `cmd_done` with `cmd_read` low returns to idle. A falling edge in state 2 enters state 3. `data_done` in state 3 returns to idle. None of these raises `soft_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-domain clock; one cycle is one timing unit |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| link_pin | input | 1 | Raw debug wire level, idles high |
| cmd_done | input | 1 | Strobe: a command has been fully received |
| cmd_read | input | 1 | Qualifies `cmd_done`: the command was a read |
| data_done | input | 1 | Strobe: the returned data is complete |
| hs_wr | input | 1 | Write strobe for the handshake enable bit |
| hs_wdata | input | 1 | Value written to the handshake enable bit |
| ack_sent | input | 1 | Strobe: an acknowledge pulse has been issued |
| wake | input | 1 | Strobe: clocks restarted after a low-power exit |
| soft_rst | output | 1 | One-cycle pulse discarding the pending transfer |
| hs_en | output | 1 | Current handshake enable |
| link_state | output | 2 | Link phase: 0 idle, 1 command, 2 read pending, 3 data return |

## Verification
The bench goes after gaps just under and just over the limit in every timed phase. A design with an off-by-a-large-margin or wrapping counter would fire early, late, or not at all. It holds a read pending for several limit lengths with handshaking on, where a design that kept timing there would drop the read. It then checks that the acknowledge brings the limit back, where a design that forgot to re-arm would hang forever. It also checks that idle stays silent, that the reset pulse is one cycle wide with the state already idle, and that a wake clears the handshake bit even while a transfer is pending.

// File: rtl/dbg_link_pkg.sv
package dbg_link_pkg;

  typedef enum logic [1:0] {
    LNK_IDLE   = 2'd0,
    LNK_CMD    = 2'd1,
    LNK_RDWAIT = 2'd2,
    LNK_DATA   = 2'd3
  } lnk_state_e;

endpackage

// File: rtl/dbg_rst_sync.sv
module dbg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_raw,
  output logic rst_n_sync
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n_raw) begin
    if (!rst_n_raw) begin
      shift_q <= '0;
    end else begin
      shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = shift_q[STAGES-1];

endmodule

// File: rtl/dbg_pin_sync.sv
module dbg_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  output logic fall
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              last_q;

  always_comb begin
    chain_d[0] = pin_raw;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    always_comb begin
      chain_d[g] = chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign fall = last_q & ~chain_q[STAGES-1];

  // R2
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);

endmodule

// File: rtl/dbg_gap_timer.sv
module dbg_gap_timer #(
  parameter int LIMIT = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic at_limit
);

  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LIM_V = W'(LIMIT);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign at_limit = (cnt_q == LIM_V);

  always_comb begin
    cnt_en = clr | ~at_limit;
    if (clr) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_limit && !clr) |=> at_limit);

  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && $past(!clr) && $past(at_limit)) |-> at_limit);

endmodule

// File: rtl/dbg_link_fsm.sv
module dbg_link_fsm
  import dbg_link_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall,
  input  logic       at_limit,
  input  logic       cmd_done,
  input  logic       cmd_read,
  input  logic       data_done,
  input  logic       hs_wr,
  input  logic       hs_wdata,
  input  logic       ack_sent,
  input  logic       wake,
  output logic       timer_clr,
  output logic       soft_rst,
  output logic       hs_en,
  output logic [1:0] state_o
);

  lnk_state_e state_q, state_d;
  logic       armed_q, armed_d;
  logic       hs_q, hs_d, hs_we;
  logic       soft_q, soft_d;
  logic       timed, timeout;
  logic       enter_rd, ack_arm;

  // which phases are timed right now
  always_comb begin
    unique case (state_q)
      LNK_CMD, LNK_DATA: timed = 1'b1;
      LNK_RDWAIT:        timed = ~hs_q | armed_q;
      default:           timed = 1'b0;
    endcase
    timeout = at_limit & timed;
  end

  // next-state
  always_comb begin
    state_d  = state_q;
    armed_d  = armed_q;
    soft_d   = 1'b0;
    enter_rd = 1'b0;
    ack_arm  = 1'b0;
    hs_we    = hs_wr | wake;
    hs_d     = wake ? 1'b0 : hs_wdata;
    if (wake) begin
      state_d = LNK_IDLE;
      armed_d = 1'b0;
      soft_d  = 1'b1;
    end else if (timeout) begin
      state_d = LNK_IDLE;
      armed_d = 1'b0;
      soft_d  = 1'b1;
    end else begin
      unique case (state_q)
        LNK_IDLE: begin
          if (fall) state_d = LNK_CMD;
        end
        LNK_CMD: begin
          if (cmd_done) begin
            if (cmd_read) begin
              state_d  = LNK_RDWAIT;
              enter_rd = 1'b1;
            end else begin
              state_d = LNK_IDLE;
            end
          end
        end
        LNK_RDWAIT: begin
          if (fall) begin
            state_d = LNK_DATA;
            armed_d = 1'b0;
          end else if (ack_sent && hs_q) begin
            armed_d = 1'b1;
            ack_arm = 1'b1;
          end
        end
        LNK_DATA: begin
          if (data_done) state_d = LNK_IDLE;
        end
        default: state_d = LNK_IDLE;
      endcase
    end
  end

  assign timer_clr = fall | wake | enter_rd | ack_arm;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LNK_IDLE;
      armed_q <= 1'b0;
      soft_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
      soft_q  <= soft_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
    end else if (hs_we) begin
      hs_q <= hs_d;
    end
  end

  assign soft_rst = soft_q;
  assign hs_en    = hs_q;
  assign state_o  = state_q;

  // R8
  soft_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_q |-> (state_q == LNK_IDLE));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LNK_IDLE && !wake) |=> !soft_q);

  // R5
  hs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LNK_RDWAIT && hs_q && !armed_q && !wake) |=> !soft_q);

  // R10
  wake_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (soft_q && !hs_q && state_q == LNK_IDLE));

endmodule

// File: rtl/dbg_link_watchdog.sv
module dbg_link_watchdog #(
  parameter int TIMEOUT_CYC = 512,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_pin,
  input  logic       cmd_done,
  input  logic       cmd_read,
  input  logic       data_done,
  input  logic       hs_wr,
  input  logic       hs_wdata,
  input  logic       ack_sent,
  input  logic       wake,
  output logic       soft_rst,
  output logic       hs_en,
  output logic [1:0] link_state
);

  logic rst_n_int;
  logic fall;
  logic at_limit;
  logic timer_clr;

  dbg_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n_raw  (rst_n),
    .rst_n_sync (rst_n_int)
  );

  dbg_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .pin_raw (link_pin),
    .fall    (fall)
  );

  dbg_gap_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .clr      (timer_clr),
    .at_limit (at_limit)
  );

  dbg_link_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .fall      (fall),
    .at_limit  (at_limit),
    .cmd_done  (cmd_done),
    .cmd_read  (cmd_read),
    .data_done (data_done),
    .hs_wr     (hs_wr),
    .hs_wdata  (hs_wdata),
    .ack_sent  (ack_sent),
    .wake      (wake),
    .timer_clr (timer_clr),
    .soft_rst  (soft_rst),
    .hs_en     (hs_en),
    .state_o   (link_state)
  );

endmodule

// File: tb/tb_dbg_link_watchdog.sv
`timescale 1ns/1ps
module tb_dbg_link_watchdog;

  localparam int LIM = 512;
  localparam int MAX_CYC = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_pin = 1'b1;
  logic cmd_done = 1'b0, cmd_read = 1'b0, data_done = 1'b0;
  logic hs_wr = 1'b0, hs_wdata = 1'b0, ack_sent = 1'b0, wake = 1'b0;
  logic soft_rst, hs_en;
  logic [1:0] link_state;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int pulses = 0;
  int soft_hi = 0;
  logic prev_soft = 1'b0;

  always #10 clk = ~clk;

  dbg_link_watchdog #(.TIMEOUT_CYC(LIM)) dut (
    .clk(clk), .rst_n(rst_n), .link_pin(link_pin), .cmd_done(cmd_done),
    .cmd_read(cmd_read), .data_done(data_done), .hs_wr(hs_wr),
    .hs_wdata(hs_wdata), .ack_sent(ack_sent), .wake(wake),
    .soft_rst(soft_rst), .hs_en(hs_en), .link_state(link_state)
  );

  // reference model built from the requirements
  bit         model_on = 1'b0;
  logic       m_s1, m_s2, m_prev, m_hs, m_armed, m_soft;
  logic [1:0] m_state;
  int         m_cnt;

  always @(posedge clk) begin : model
    logic f, tmo, tmd, clr;
    logic [1:0] ns;
    logic na, nsoft;
    if (model_on) begin
      f = m_prev & ~m_s2;
      tmd = (m_state == 2'd1) || (m_state == 2'd3) ||
            ((m_state == 2'd2) && (!m_hs || m_armed));
      tmo = (m_cnt == LIM) && tmd;
      ns = m_state; na = m_armed; nsoft = 1'b0; clr = f;
      if (wake) begin
        ns = 2'd0; na = 1'b0; nsoft = 1'b1; clr = 1'b1;
      end else if (tmo) begin
        ns = 2'd0; na = 1'b0; nsoft = 1'b1;
      end else begin
        case (m_state)
          2'd0: if (f) ns = 2'd1;
          2'd1: if (cmd_done) begin
                  if (cmd_read) begin ns = 2'd2; clr = 1'b1; end
                  else ns = 2'd0;
                end
          2'd2: if (f) begin ns = 2'd3; na = 1'b0; end
                else if (ack_sent && m_hs) begin na = 1'b1; clr = 1'b1; end
          default: if (data_done) ns = 2'd0;
        endcase
      end
      m_state <= ns;
      m_armed <= na;
      m_soft  <= nsoft;
      if (wake) m_hs <= 1'b0;
      else if (hs_wr) m_hs <= hs_wdata;
      m_cnt  <= clr ? 0 : ((m_cnt == LIM) ? LIM : m_cnt + 1);
      m_s1   <= link_pin;
      m_s2   <= m_s1;
      m_prev <= m_s2;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, plus pulse monitor
  always @(negedge clk) begin
    if (soft_rst === 1'b1) soft_hi++;
    if (soft_rst === 1'b1 && prev_soft !== 1'b1) pulses++;
    prev_soft = soft_rst;
    if (model_on && !done) begin
      chk(link_state === m_state, "R3", "state vs model", link_state, m_state);
      chk(soft_rst === m_soft, "R8", "soft_rst vs model", soft_rst, m_soft);
      chk(hs_en === m_hs, "R11", "hs_en vs model", hs_en, m_hs);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_edge();
    @(negedge clk) link_pin = 1'b0;
    @(negedge clk);
    @(negedge clk) link_pin = 1'b1;
  endtask

  task automatic cmd(input logic rd);
    @(negedge clk) begin cmd_done = 1'b1; cmd_read = rd; end
    @(negedge clk) begin cmd_done = 1'b0; cmd_read = 1'b0; end
  endtask

  task automatic ddone();
    @(negedge clk) data_done = 1'b1;
    @(negedge clk) data_done = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk) ack_sent = 1'b1;
    @(negedge clk) ack_sent = 1'b0;
  endtask

  task automatic hs_set(input logic v);
    @(negedge clk) begin hs_wr = 1'b1; hs_wdata = v; end
    @(negedge clk) begin hs_wr = 1'b0; hs_wdata = 1'b0; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", MAX_CYC, 0);
      finish_run();
    end
  end

  initial begin : stim
    int p0, h0;
    void'($urandom(32'd7351));
    cyc(3);
    rst_n = 1'b1;
    cyc(5);
    // R1 reset state
    chk(link_state == 2'd0, "R1", "state after reset", link_state, 0);
    chk(soft_rst == 1'b0, "R1", "soft_rst after reset", soft_rst, 0);
    chk(hs_en == 1'b0, "R1", "hs_en after reset", hs_en, 0);
    m_s1 = 1'b1; m_s2 = 1'b1; m_prev = 1'b1; m_hs = 1'b0; m_armed = 1'b0;
    m_soft = 1'b0; m_state = 2'd0; m_cnt = LIM;
    model_on = 1'b1;

    // R7 idle stays quiet
    p0 = pulses;
    cyc(1500);
    chk(pulses == p0, "R7", "pulses while idle", pulses - p0, 0);

    // R2 edge latency: pin low, state after third clock edge
    @(negedge clk) link_pin = 1'b0;
    cyc(2);
    chk(link_state == 2'd0, "R2", "state two edges after pin low", link_state, 0);
    cyc(1);
    chk(link_state == 2'd1, "R2", "state three edges after pin low", link_state, 1);
    link_pin = 1'b1;

    // R3 edges under the limit keep the command alive
    p0 = pulses;
    cyc(400);
    pin_edge();
    cyc(400);
    chk(link_state == 2'd1, "R3", "command kept alive", link_state, 1);
    chk(pulses == p0, "R3", "no early timeout", pulses - p0, 0);
    h0 = soft_hi;
    cyc(200);
    chk(link_state == 2'd0, "R3", "command timed out", link_state, 0);
    chk(pulses == p0 + 1, "R3", "one timeout pulse", pulses - p0, 1);
    chk(soft_hi == h0 + 1, "R8", "pulse width in cycles", soft_hi - h0, 1);

    // R9 next edge after timeout starts a command
    pin_edge();
    cyc(5);
    chk(link_state == 2'd1, "R9", "new command after timeout", link_state, 1);

    // R4 read without handshake
    cmd(1'b1);
    cyc(3);
    chk(link_state == 2'd2, "R4", "read pending", link_state, 2);
    p0 = pulses;
    cyc(450);
    chk(link_state == 2'd2, "R4", "read still pending", link_state, 2);
    cyc(100);
    chk(link_state == 2'd0, "R4", "uncollected read dropped", link_state, 0);
    chk(pulses == p0 + 1, "R4", "read timeout pulse", pulses - p0, 1);

    // R5/R6 handshake
    hs_set(1'b1);
    chk(hs_en == 1'b1, "R11", "hs_en written", hs_en, 1);
    pin_edge(); cyc(5); cmd(1'b1);
    p0 = pulses;
    cyc(2000);
    chk(link_state == 2'd2, "R5", "read held under handshake", link_state, 2);
    chk(pulses == p0, "R5", "no timeout under handshake", pulses - p0, 0);
    ack();
    cyc(450);
    chk(link_state == 2'd2, "R6", "read alive after ack", link_state, 2);
    cyc(100);
    chk(link_state == 2'd0, "R6", "read dropped after ack", link_state, 0);
    chk(pulses == p0 + 1, "R6", "ack re-armed pulse", pulses - p0, 1);

    // R12 normal completions
    p0 = pulses;
    pin_edge(); cyc(5); cmd(1'b0); cyc(2);
    chk(link_state == 2'd0, "R12", "write command done", link_state, 0);
    pin_edge(); cyc(5); cmd(1'b1); cyc(10); pin_edge(); cyc(5);
    chk(link_state == 2'd3, "R12", "data return entered", link_state, 3);
    ddone(); cyc(2);
    chk(link_state == 2'd0, "R12", "data return done", link_state, 0);
    chk(pulses == p0, "R12", "no pulse on completion", pulses - p0, 0);

    // R10 wake during a command
    pin_edge(); cyc(5);
    @(negedge clk) wake = 1'b1;
    @(negedge clk) wake = 1'b0;
    chk(soft_rst == 1'b1, "R10", "wake soft reset", soft_rst, 1);
    chk(link_state == 2'd0, "R10", "wake to idle", link_state, 0);
    chk(hs_en == 1'b0, "R10", "wake clears hs_en", hs_en, 0);

    // R11 write and wake together: wake wins
    @(negedge clk) begin hs_wr = 1'b1; hs_wdata = 1'b1; wake = 1'b1; end
    @(negedge clk) begin hs_wr = 1'b0; hs_wdata = 1'b0; wake = 1'b0; end
    chk(hs_en == 1'b0, "R11", "wake beats write", hs_en, 0);
    cyc(3);

    // constrained random traffic checked by the model
    for (int i = 0; i < 250; i++) begin
      int a, g;
      a = $urandom % 16;
      case ($urandom % 4)
        0: g = 1 + $urandom % 20;
        1: g = 495 + $urandom % 30;
        2: g = 600 + $urandom % 300;
        default: g = 30 + $urandom % 200;
      endcase
      if (a <= 5) pin_edge();
      else if (a <= 8) cmd(1'b1);
      else if (a == 9) cmd(1'b0);
      else if (a <= 11) ddone();
      else if (a <= 13) ack();
      else if (a == 14) hs_set(1'($urandom % 2));
      else if ($urandom % 4 == 0) begin
        @(negedge clk) wake = 1'b1;
        @(negedge clk) wake = 1'b0;
      end else pin_edge();
      cyc(g);
    end
    finish_run();
  end

endmodule